// File: doc/BRIEF.md
# Redirection-Based Interrupt Delivery Engine

This block turns interrupt input lines into address/data interrupt messages. Every pin owns one 64-bit redirection entry holding a vector, a delivery-mode code, a destination field, a destination-mode bit, a trigger-mode bit and a mask. The engine watches the input levels. It keeps one pending bit per pin and runs service passes. A pass walks the pins from lowest to highest and, for each pin it serves, emits one message on a valid/ready port.

Edge pins are consumed when they are served. Level pins are coalesced: serving one sets a read-only remote-pending flag in its entry. No further message leaves for that pin until an end-of-interrupt broadcast carrying the entry's vector clears the flag. If the pin is still unmasked and pending at that point, another pass runs. Software reads and writes the entries through a simple side port.

Top module: `irq_route_engine`

## Requirements
- R1: After reset no message is offered, every pending bit and remote-pending flag is clear, and every entry reads back as zero.
- R2: Input line 0 drives pin 2 (ORed with input line 2). Every other input line k drives pin k, and pin 0 never becomes pending.
- R3: A rising input on an edge-mode pin (entry bit 15 = 0) whose mask (entry bit 16) is set is discarded, so unmasking the pin later sends nothing. On an unmasked edge pin it sets pending and yields exactly one message, and serving the pin clears its pending bit.
- R4: A rising input on a level-mode pin (bit 15 = 1) sets pending whatever the mask. Serving the pin sets remote-pending, which reads back in entry bit 14, and a message is sent only if remote-pending was clear before. A falling input clears the pin's pending bit.
- R5: A pass visits pins in ascending order, skips pins that are not pending or are masked, and emits messages in that order.
- R6: The message address is 0xFEE00000 | (entry[63:48] << 4) | (entry[11] << 2).
- R7: The message data is entry[7:0] | (entry[10:8] << 8) | (entry[15] << 15), with all other bits zero.
- R8: An end-of-interrupt with vector V clears remote-pending on every entry whose flag is set and whose entry[7:0] equals V. If such an entry is unmasked and still pending, a new pass runs and sends its message again.
- R9: While the message is valid and not ready, valid stays high and the address and data stay unchanged. Each accepted handshake carries exactly one message.
- R10: A table write stores only bits 7:0, 10:8, 11, 15, 16 and 63:48, and all other bits read back as zero. Bit 14 cannot be written. A write with bit 15 = 0 clears the entry's remote-pending flag. Every write starts a service pass.
- R11: With the engine idle, a single unmasked edge event on pin p raises message valid on the (p+3)-th rising clock edge, counting the edge that samples the input as the first.
- R12: Input events or end-of-interrupt broadcasts that arrive during a pass are not lost: a further pass runs after the current one ends, even for pins the current pass has already passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_PINS | Interrupt input levels |
| tbl_wr_i | input | 1 | Entry write strobe |
| tbl_idx_i | input | IDX_W | Entry index for reads and writes |
| tbl_wdata_i | input | 64 | Entry write data |
| tbl_rdata_o | output | 64 | Entry read data, remote-pending in bit 14 |
| eoi_valid_i | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector_i | input | 8 | Vector carried by the broadcast |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Message accepted by the sink |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
Input edges and table writes take effect on the next clock edge, a pass begins one edge after that, and pin p is decided p edges later. A lone event on pin p is therefore due on the (p+3)-th edge. One directed case counts exactly that latency. Every other case waits for a bounded window that covers a full pass plus sink stalls, then compares the list of accepted messages with the list the bench predicts. Read-back values are sampled combinationally between edges, after the write or broadcast has been clocked.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
  localparam int unsigned ENTRY_W   = 64;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned DLV_LSB   = 8;
  localparam int unsigned DMODE_BIT = 11;
  localparam int unsigned RPEND_BIT = 14;
  localparam int unsigned TRIG_BIT  = 15;
  localparam int unsigned MASK_BIT  = 16;
  localparam int unsigned DEST_LSB  = 48;

  localparam logic [31:0]        MSG_BASE = 32'hFEE0_0000;
  localparam logic [ENTRY_W-1:0] RW_MASK  = 64'hFFFF_0000_0001_8FFF;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_SEND} svc_state_e;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
  } msg_t;

  function automatic msg_t build_msg(input logic [ENTRY_W-1:0] e);
    msg_t m;
    m.addr = MSG_BASE
           | ({16'h0, e[DEST_LSB +: 16]} << 4)
           | ({31'h0, e[DMODE_BIT]} << 2);
    m.data = {24'h0, e[VEC_W-1:0]}
           | ({29'h0, e[DLV_LSB +: 3]} << 8)
           | ({31'h0, e[TRIG_BIT]} << 15);
    return m;
  endfunction
endpackage

// File: rtl/irq_pin_map.sv
`timescale 1ns/1ps
module irq_pin_map #(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);
  logic [NUM_PINS-1:0] lvl, prev_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    if (p == 0) begin : g_zero
      assign lvl[p] = 1'b0;
    end else if (p == 2) begin : g_two
      assign lvl[p] = irq_i[0] | irq_i[2];
    end else begin : g_direct
      assign lvl[p] = irq_i[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl;
  end

  assign rise_o = lvl & ~prev_q;
  assign fall_o = ~lvl & prev_q;
endmodule

// File: rtl/irq_entry_table.sv
`timescale 1ns/1ps
module irq_entry_table
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic [IDX_W-1:0]                  idx_i,
  input  logic [ENTRY_W-1:0]                wdata_i,
  output logic [ENTRY_W-1:0]                rdata_o,
  output logic [NUM_PINS-1:0][ENTRY_W-1:0]  entries_o,
  input  logic                              set_rpend_i,
  input  logic [IDX_W-1:0]                  set_idx_i,
  input  logic                              eoi_i,
  input  logic [VEC_W-1:0]                  eoi_vec_i,
  output logic [NUM_PINS-1:0]               eoi_hit_o
);
  logic [NUM_PINS-1:0][ENTRY_W-1:0] ent_q;
  logic [NUM_PINS-1:0]              rpend_q, rpend_d;
  logic                             idx_ok;

  assign idx_ok = int'(idx_i) < NUM_PINS;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      eoi_hit_o[p] = eoi_i && rpend_q[p] && (ent_q[p][VEC_W-1:0] == eoi_vec_i);
      rpend_d[p]   = rpend_q[p];
      if (set_rpend_i && set_idx_i == IDX_W'(p)) rpend_d[p] = 1'b1;
      if (eoi_hit_o[p])                           rpend_d[p] = 1'b0;
      // edge-mode writes drop a stale remote-pending flag
      if (wr_i && idx_i == IDX_W'(p) && !wdata_i[TRIG_BIT]) rpend_d[p] = 1'b0;
      entries_o[p] = ent_q[p] | ({{(ENTRY_W-1){1'b0}}, rpend_q[p]} << RPEND_BIT);
    end
  end

  assign rdata_o = idx_ok ? entries_o[idx_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q   <= '0;
      rpend_q <= '0;
    end else begin
      rpend_q <= rpend_d;
      if (wr_i && idx_ok) ent_q[idx_i] <= wdata_i & RW_MASK;
    end
  end

  p_eoi_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eoi_hit_o) |=> ((rpend_q & $past(eoi_hit_o)) == '0));

  p_edge_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_ok && !wdata_i[TRIG_BIT]) |=> !rpend_q[$past(idx_i)]);
endmodule

// File: rtl/irq_service.sv
`timescale 1ns/1ps
module irq_service
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PINS-1:0]               rise_i,
  input  logic [NUM_PINS-1:0]               fall_i,
  input  logic [NUM_PINS-1:0][ENTRY_W-1:0]  entries_i,
  input  logic [NUM_PINS-1:0]               eoi_hit_i,
  input  logic                              tbl_wr_i,
  output logic                              set_rpend_o,
  output logic [IDX_W-1:0]                  set_idx_o,
  output logic                              msg_valid_o,
  input  logic                              msg_ready_i,
  output logic [31:0]                       msg_addr_o,
  output logic [31:0]                       msg_data_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PINS - 1);

  svc_state_e          state_q, state_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [NUM_PINS-1:0] pend_q, pend_d;
  logic [NUM_PINS-1:0] mask_v, lvl_v, rp_v;
  logic                rerun_q, rerun_d, clr_rerun, kick;
  msg_t                msg_q, msg_d;
  logic [ENTRY_W-1:0]  cur;
  logic                hit, edge_hit, lvl_hit, issue, advance;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      mask_v[p] = entries_i[p][MASK_BIT];
      lvl_v[p]  = entries_i[p][TRIG_BIT];
      rp_v[p]   = entries_i[p][RPEND_BIT];
    end
  end

  assign cur      = entries_i[idx_q];
  assign hit      = (state_q == ST_SCAN) && pend_q[idx_q] && !mask_v[idx_q];
  assign edge_hit = hit && !lvl_v[idx_q];
  assign lvl_hit  = hit && lvl_v[idx_q];
  assign issue    = edge_hit || (lvl_hit && !rp_v[idx_q]);

  assign set_rpend_o = lvl_hit;
  assign set_idx_o   = idx_q;

  // anything that may make a pin serviceable requests another pass
  assign kick = (|(rise_i & lvl_v & ~rp_v))
              | (|(rise_i & ~lvl_v & ~mask_v))
              | (|(eoi_hit_i & ~mask_v & pend_q))
              | tbl_wr_i;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      pend_d[p] = pend_q[p];
      if (edge_hit && idx_q == IDX_W'(p))   pend_d[p] = 1'b0;
      if (fall_i[p] && lvl_v[p])            pend_d[p] = 1'b0;
      if (rise_i[p] && (lvl_v[p] || !mask_v[p])) pend_d[p] = 1'b1;
    end
  end

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    msg_d     = msg_q;
    clr_rerun = 1'b0;
    advance   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (rerun_q) begin
        state_d   = ST_SCAN;
        idx_d     = '0;
        clr_rerun = 1'b1;
      end
      ST_SCAN: if (issue) begin
        state_d = ST_SEND;
        msg_d   = build_msg(cur);
      end else begin
        advance = 1'b1;
      end
      ST_SEND: advance = msg_ready_i;
      default: state_d = ST_IDLE;
    endcase
    if (advance) begin
      if (idx_q == LAST_IDX) begin
        if (rerun_q) begin
          state_d   = ST_SCAN;
          idx_d     = '0;
          clr_rerun = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end else begin
        state_d = ST_SCAN;
        idx_d   = idx_q + 1'b1;
      end
    end
    rerun_d = (rerun_q & ~clr_rerun) | kick;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pend_q  <= '0;
      rerun_q <= 1'b0;
      msg_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pend_q  <= pend_d;
      rerun_q <= rerun_d;
      msg_q   <= msg_d;
    end
  end

  assign msg_valid_o = (state_q == ST_SEND);
  assign msg_addr_o  = msg_q.addr;
  assign msg_data_o  = msg_q.data;

  p_msg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=>
      (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));

  p_addr_fmt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_addr_o[31:20] == 12'hFEE && msg_addr_o[3] == 1'b0
                     && msg_addr_o[1:0] == 2'b00));

  p_data_fmt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_data_o[31:16] == 16'h0 && msg_data_o[14:11] == 4'h0));

  p_pin0_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q[0]);

  p_lvl_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(fall_i & lvl_v)) |=> ((pend_q & $past(fall_i & lvl_v)) == '0));
endmodule

// File: rtl/irq_route_engine.sv
`timescale 1ns/1ps
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter  int unsigned NUM_PINS = 24,
  localparam int unsigned IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic                tbl_wr_i,
  input  logic [IDX_W-1:0]    tbl_idx_i,
  input  logic [63:0]         tbl_wdata_i,
  output logic [63:0]         tbl_rdata_o,
  input  logic                eoi_valid_i,
  input  logic [7:0]          eoi_vector_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [31:0]         msg_addr_o,
  output logic [31:0]         msg_data_o
);
  logic [NUM_PINS-1:0]              rise, fall, eoi_hit;
  logic [NUM_PINS-1:0][ENTRY_W-1:0] entries;
  logic                             set_rpend;
  logic [IDX_W-1:0]                 set_idx;

  irq_pin_map #(.NUM_PINS(NUM_PINS)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  irq_entry_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (tbl_wr_i),
    .idx_i       (tbl_idx_i),
    .wdata_i     (tbl_wdata_i),
    .rdata_o     (tbl_rdata_o),
    .entries_o   (entries),
    .set_rpend_i (set_rpend),
    .set_idx_i   (set_idx),
    .eoi_i       (eoi_valid_i),
    .eoi_vec_i   (eoi_vector_i),
    .eoi_hit_o   (eoi_hit)
  );

  irq_service #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_svc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .fall_i      (fall),
    .entries_i   (entries),
    .eoi_hit_i   (eoi_hit),
    .tbl_wr_i    (tbl_wr_i),
    .set_rpend_o (set_rpend),
    .set_idx_o   (set_idx),
    .msg_valid_o (msg_valid_o),
    .msg_ready_i (msg_ready_i),
    .msg_addr_o  (msg_addr_o),
    .msg_data_o  (msg_data_o)
  );
endmodule

// File: tb/irq_route_engine_test.sv
`timescale 1ns/1ps
module irq_route_engine_test;
  localparam int N  = 24;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          tbl_wr = 1'b0;
  logic [IW-1:0] tbl_idx = '0;
  logic [63:0]   tbl_wdata = '0;
  logic [63:0]   tbl_rdata;
  logic          eoi_valid = 1'b0;
  logic [7:0]    eoi_vector = '0;
  logic          msg_valid;
  logic          msg_ready = 1'b0;
  logic [31:0]   msg_addr, msg_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] got_a[8];
  logic [31:0] got_d[8];
  int          got_n;

  logic [63:0] m_ent[N];
  bit          m_rp[N];

  irq_route_engine #(.NUM_PINS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .tbl_wr_i(tbl_wr), .tbl_idx_i(tbl_idx), .tbl_wdata_i(tbl_wdata),
    .tbl_rdata_o(tbl_rdata), .eoi_valid_i(eoi_valid), .eoi_vector_i(eoi_vector),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  always #2 clk = ~clk;

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dm,
                                     input logic dmode, input logic trig,
                                     input logic mask, input logic [15:0] dest);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = dm; e[11] = dmode; e[15] = trig; e[16] = mask;
    e[63:48] = dest;
    return e;
  endfunction

  function automatic logic [63:0] keep(input logic [63:0] e);
    return mk(e[7:0], e[10:8], e[11], e[15], e[16], e[63:48]);
  endfunction

  function automatic logic [31:0] exp_addr(input logic [63:0] e);
    return 32'hFEE00000 | {12'h0, e[63:48], 4'h0} | (e[11] ? 32'd4 : 32'd0);
  endfunction

  function automatic logic [31:0] exp_data(input logic [63:0] e);
    return {16'h0, e[15], 4'h0, e[10:8], e[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_entry(input int idx, input logic [63:0] d);
    @(negedge clk);
    tbl_wr = 1'b1; tbl_idx = IW'(idx); tbl_wdata = d;
    @(negedge clk);
    tbl_wr = 1'b0;
  endtask

  task automatic read_entry(input int idx, output logic [63:0] d);
    @(negedge clk);
    tbl_idx = IW'(idx);
    #1 d = tbl_rdata;
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic collect(input int cycles);
    got_n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      msg_ready = (c == cycles - 1) ? 1'b0 : (($urandom % 10) < 7);
      if (msg_valid && msg_ready) begin
        if (got_n < 8) begin
          got_a[got_n] = msg_addr;
          got_d[got_n] = msg_data;
        end
        got_n++;
      end
    end
  endtask

  task automatic set_irq(input int q, input logic v);
    @(negedge clk);
    irq[q] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic [63:0] e;
    int k;
    void'($urandom(32'd20240611));
    for (int p = 0; p < N; p++) begin m_ent[p] = '0; m_rp[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(msg_valid == 1'b0, "R1 valid after reset", 64'(msg_valid), 64'd0);
    read_entry(5, rd);
    chk(rd == 64'h0, "R1 entry after reset", rd, 64'h0);

    // R11 exact latency, R6/R7 format
    e = mk(8'h41, 3'd3, 1'b1, 1'b0, 1'b0, 16'h1234);
    write_entry(6, e);
    collect(60);
    chk(got_n == 0, "R10 write with nothing pending", 64'(got_n), 64'd0);
    @(negedge clk);
    irq[6] = 1'b1;
    k = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      k++;
      if (msg_valid) break;
    end
    chk(k == 6 + 3, "R11 latency pin 6", 64'(k), 64'd9);
    chk(msg_addr == exp_addr(e), "R6 address", 64'(msg_addr), 64'(exp_addr(e)));
    chk(msg_data == exp_data(e), "R7 data", 64'(msg_data), 64'(exp_data(e)));
    collect(10);
    chk(got_n == 1, "R9 one handshake", 64'(got_n), 64'd1);
    set_irq(6, 1'b0);

    // R2 input 0 drives pin 2
    write_entry(0, mk(8'h50, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    write_entry(2, mk(8'h52, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0002));
    collect(60);
    set_irq(0, 1'b1);
    collect(80);
    chk(got_n == 1, "R2 count from input 0", 64'(got_n), 64'd1);
    chk(got_d[0][7:0] == 8'h52, "R2 pin 2 vector", 64'(got_d[0]), 64'h152);
    set_irq(0, 1'b0);

    // R5 ordering with stalls
    write_entry(3, mk(8'h63, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0003));
    write_entry(9, mk(8'h69, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0009));
    collect(60);
    @(negedge clk);
    irq[3] = 1'b1; irq[9] = 1'b1;
    collect(100);
    chk(got_n == 2, "R5 two messages", 64'(got_n), 64'd2);
    chk(got_d[0][7:0] == 8'h63, "R5 first is pin 3", 64'(got_d[0]), 64'h63);
    chk(got_d[1][7:0] == 8'h69, "R5 second is pin 9", 64'(got_d[1]), 64'h69);
    @(negedge clk);
    irq[3] = 1'b0; irq[9] = 1'b0;

    // R3 masked edge dropped
    write_entry(10, mk(8'h7A, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0));
    collect(60);
    set_irq(10, 1'b1);
    collect(60);
    chk(got_n == 0, "R3 masked edge", 64'(got_n), 64'd0);
    set_irq(10, 1'b0);
    write_entry(10, mk(8'h7A, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    collect(60);
    chk(got_n == 0, "R3 dropped edge stays dropped", 64'(got_n), 64'd0);

    // R4/R8 level coalescing and re-arm
    write_entry(12, mk(8'h8C, 3'd2, 1'b0, 1'b1, 1'b0, 16'h00CC));
    collect(60);
    set_irq(12, 1'b1);
    collect(80);
    chk(got_n == 1, "R4 level first message", 64'(got_n), 64'd1);
    read_entry(12, rd);
    chk(rd[14] == 1'b1, "R4 remote-pending set", rd, 64'(rd) | 64'h4000);
    send_eoi(8'h8D);
    collect(60);
    chk(got_n == 0, "R8 wrong vector", 64'(got_n), 64'd0);
    send_eoi(8'h8C);
    collect(80);
    chk(got_n == 1, "R8 re-arm while pending", 64'(got_n), 64'd1);
    set_irq(12, 1'b0);
    send_eoi(8'h8C);
    collect(60);
    chk(got_n == 0, "R4 dropped level not resent", 64'(got_n), 64'd0);
    read_entry(12, rd);
    chk(rd[14] == 1'b0, "R8 remote-pending cleared", rd, rd & ~64'h4000);
    set_irq(12, 1'b1);
    collect(80);
    chk(got_n == 1, "R4 level again", 64'(got_n), 64'd1);
    set_irq(12, 1'b0);
    write_entry(12, mk(8'h8C, 3'd2, 1'b0, 1'b0, 1'b0, 16'h00CC) | 64'h0000_00FF_0000_6000);
    read_entry(12, rd);
    e = mk(8'h8C, 3'd2, 1'b0, 1'b0, 1'b0, 16'h00CC);
    chk(rd == e, "R10 edge write clears flag and filters", rd, e);
    collect(40);

    // R4 masked level then unmask through a write
    write_entry(14, mk(8'h9E, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0));
    collect(60);
    set_irq(14, 1'b1);
    collect(60);
    chk(got_n == 0, "R5 masked level skipped", 64'(got_n), 64'd0);
    write_entry(14, mk(8'h9E, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0));
    collect(80);
    chk(got_n == 1, "R10 write starts pass", 64'(got_n), 64'd1);
    set_irq(14, 1'b0);
    send_eoi(8'h9E);
    collect(40);

    // R12 event during a stalled pass
    write_entry(20, mk(8'hB4, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    write_entry(4, mk(8'hA4, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    collect(60);
    @(negedge clk);
    msg_ready = 1'b0;
    irq[20] = 1'b1;
    repeat (40) @(negedge clk);
    chk(msg_valid && msg_data[7:0] == 8'hB4, "R9 stalled message held",
        64'(msg_data), 64'hB4);
    irq[4] = 1'b1;
    repeat (3) @(negedge clk);
    collect(100);
    chk(got_n == 2, "R12 later pass count", 64'(got_n), 64'd2);
    chk(got_d[1][7:0] == 8'hA4, "R12 pin 4 served later", 64'(got_d[1]), 64'hA4);
    @(negedge clk);
    irq[4] = 1'b0; irq[20] = 1'b0;
    collect(40);

    for (int p = 0; p < N; p++) begin
      read_entry(p, rd);
      m_ent[p] = keep(rd);
      m_rp[p]  = rd[14];
    end

    // constrained random
    for (int it = 0; it < 60; it++) begin
      int q, pin, expn;
      logic [63:0] junk;
      logic [7:0] ev;
      q   = $urandom_range(N - 1, 0);
      pin = (q == 0) ? 2 : q;
      e = mk(8'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
             ($urandom % 4) == 0, 16'($urandom));
      junk = {$urandom, $urandom};
      write_entry(pin, e | (junk & 64'h0000_FFFF_FFFE_7000));
      m_ent[pin] = e;
      if (!e[15]) m_rp[pin] = 0;
      collect(40);
      chk(got_n == 0, "R10 random write quiet", 64'(got_n), 64'd0);
      read_entry(pin, rd);
      chk(rd == (m_ent[pin] | (m_rp[pin] ? 64'h4000 : 64'h0)), "R10 random readback",
          rd, m_ent[pin] | (m_rp[pin] ? 64'h4000 : 64'h0));
      expn = 0;
      if (!e[16]) begin
        if (!e[15]) expn = 1;
        else if (!m_rp[pin]) expn = 1;
      end
      if (!e[16] && e[15]) m_rp[pin] = 1;
      set_irq(q, 1'b1);
      collect(80);
      chk(got_n == expn, e[15] ? "R4 random level count" : "R3 random edge count",
          64'(got_n), 64'(expn));
      if (expn == 1 && got_n == 1) begin
        chk(got_a[0] == exp_addr(e), "R6 random address", 64'(got_a[0]), 64'(exp_addr(e)));
        chk(got_d[0] == exp_data(e), "R7 random data", 64'(got_d[0]), 64'(exp_data(e)));
      end
      set_irq(q, 1'b0);
      repeat (3) @(negedge clk);
      ev = ($urandom % 2) ? e[7:0] : 8'($urandom);
      send_eoi(ev);
      for (int p = 0; p < N; p++)
        if (m_rp[p] && m_ent[p][7:0] == ev) m_rp[p] = 0;
      collect(20);
      chk(got_n == 0, "R8 random broadcast quiet", 64'(got_n), 64'd0);
      read_entry(pin, rd);
      chk(rd[14] == m_rp[pin], "R8 random flag", 64'(rd[14]), 64'(m_rp[pin]));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule